// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This block performs decimal arithmetic on bytes that each carry two packed BCD digits. It can add, subtract or negate with the extend bit included. A destination byte and a source byte enter together with an operation code, the incoming extend bit and the incoming zero flag. The block returns a result byte and a fresh set of extend, carry, zero, negative and overflow flags.

The unit takes one operation for each cycle in which the valid strobe is high. It registers the result and the flags on that edge and keeps them until the next accepted operation. Decimal numbers longer than one byte are processed one byte at a time, lowest byte first. The caller feeds the extend output back into the extend input. It also feeds the zero output back into the zero input, after setting that input to 1 for the first byte, so that the final zero flag describes the whole string.

Top module: `bcd_arith_unit`

## Requirements
- R1: One cycle after reset is asserted, the result and all five flag outputs are 0.
- R2: Operation code 0 (add) gives the result (dst + src + X) modulo 100 in packed BCD. C and X are both set when the decimal sum reaches 100 and are both cleared otherwise.
- R3: Operation code 1 (subtract) gives (dst - src - X) modulo 100 in packed BCD. C and X are both set on a decimal borrow and are both cleared otherwise.
- R4: Operation code 2 (negate) gives (0 - src - X) modulo 100 and ignores dst. This is the ten's complement of src when X is 0 and the nine's complement when X is 1. C and X are both set whenever the result borrows.
- R5: The zero output is cleared when the result byte is non-zero. Otherwise it copies the zero input. A chained string therefore reports zero only when every byte is zero.
- R6: N equals bit 7 of the result and V is always 0 after an accepted operation.
- R7: Result and flags update on the clock edge where the valid strobe is high, so they are visible in the following cycle. They hold while the strobe is low.
- R8: Operation code 3 is reserved. A strobe that carries it leaves the result and all flags unchanged.
- R9: Digits A to F are not flagged as errors. For each digit, from low to high with a ripple carry, add uses the binary sum of the two digits plus the carry in; when that sum exceeds 9, 6 is added and a carry passes up. Subtract uses the binary difference; when it goes negative, 6 is taken off and a borrow passes up. The digit is always the low four bits of the corrected value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 0 add, 1 subtract, 2 negate, 3 reserved |
| src_i | input | 8 | Source byte (two BCD digits) |
| dst_i | input | 8 | Destination byte (two BCD digits) |
| x_i | input | 1 | Incoming extend bit |
| z_i | input | 1 | Incoming zero flag |
| res_o | output | 8 | Registered result byte |
| x_o | output | 1 | Extend flag out |
| c_o | output | 1 | Carry/borrow flag out |
| z_o | output | 1 | Zero flag out |
| n_o | output | 1 | Bit 7 of the result |
| v_o | output | 1 | Overflow flag, always 0 |

## Verification
The digit-range assertion assumes that both operand digits are legal BCD (0 to 9). Under that assumption the corrected digit can never exceed 9, so the check applies only when its inputs are legal. The random stimulus builds every operand from two draws in the range 0 to 9. The only non-BCD values come from a few directed cases aimed at the defined digit correction. The flag properties assume that the caller sets the zero input to 1 at the start of each string. The chained-string sequences follow that rule.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_NEG = 2'd2,
    OP_RSV = 2'd3
  } bcd_op_e;

  localparam int DIGIT_W = 4;
endpackage

// File: rtl/bcd_digit.sv
module bcd_digit
  import bcd_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  input  logic               cin_i,
  input  logic               sub_i,
  output logic [DIGIT_W-1:0] d_o,
  output logic               cout_o
);
  logic [DIGIT_W:0] raw;
  logic [DIGIT_W:0] fixed;
  logic             adj;

  always_comb begin
    if (sub_i) begin
      raw = {1'b0, a_i} - {1'b0, b_i} - {{DIGIT_W{1'b0}}, cin_i};
      adj = raw[DIGIT_W];
      fixed = adj ? (raw - (DIGIT_W+1)'(6)) : raw;
    end else begin
      raw = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, cin_i};
      adj = (raw > (DIGIT_W+1)'(9));
      fixed = adj ? (raw + (DIGIT_W+1)'(6)) : raw;
    end
    d_o    = fixed[DIGIT_W-1:0];
    cout_o = adj;
  end

  always_comb begin
    if (a_i <= 4'd9 && b_i <= 4'd9)
      AST_DIGIT_RANGE: assert (d_o <= 4'd9); // R2
  end
endmodule

// File: rtl/bcd_core.sv
module bcd_core
  import bcd_pkg::*;
#(
  parameter int NDIG = 2,
  localparam int W = NDIG * DIGIT_W
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  input  logic         x_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);
  logic [W-1:0]  minuend;
  logic          is_sub;
  logic [NDIG:0] chain;

  always_comb begin
    is_sub  = (op_i != OP_ADD);
    minuend = (op_i == OP_NEG) ? '0 : dst_i;
  end

  assign chain[0] = x_i;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    bcd_digit u_dig (
      .a_i   (minuend[g*DIGIT_W +: DIGIT_W]),
      .b_i   (src_i[g*DIGIT_W +: DIGIT_W]),
      .cin_i (chain[g]),
      .sub_i (is_sub),
      .d_o   (res_o[g*DIGIT_W +: DIGIT_W]),
      .cout_o(chain[g+1])
    );
  end

  assign carry_o = chain[NDIG];
endmodule

// File: rtl/bcd_arith_unit.sv
module bcd_arith_unit
  import bcd_pkg::*;
#(
  parameter int NDIG = 2,
  localparam int W = NDIG * DIGIT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  input  logic         x_i,
  input  logic         z_i,
  output logic [W-1:0] res_o,
  output logic         x_o,
  output logic         c_o,
  output logic         z_o,
  output logic         n_o,
  output logic         v_o
);
  logic [W-1:0] core_res;
  logic         core_carry;
  logic         accept;

  bcd_core #(.NDIG(NDIG)) u_core (
    .op_i   (op_i),
    .src_i  (src_i),
    .dst_i  (dst_i),
    .x_i    (x_i),
    .res_o  (core_res),
    .carry_o(core_carry)
  );

  assign accept = valid_i && (op_i != OP_RSV);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      x_o   <= 1'b0;
      c_o   <= 1'b0;
      z_o   <= 1'b0;
      n_o   <= 1'b0;
      v_o   <= 1'b0;
    end else if (accept) begin
      res_o <= core_res;
      x_o   <= core_carry;
      c_o   <= core_carry;
      z_o   <= (core_res != '0) ? 1'b0 : z_i;
      n_o   <= core_res[W-1];
      v_o   <= 1'b0;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !x_o && !c_o && !z_o && !n_o && !v_o)); // R1

  AST_Z_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (accept && !z_i) |=> !z_o); // R5

  AST_Z_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (accept && z_i) |=> (z_o == (res_o == '0))); // R5

  AST_N_FROM_MSB: assert property (@(posedge clk) disable iff (rst)
    accept |=> (n_o == res_o[W-1] && !v_o)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(res_o) && $stable(x_o) && $stable(c_o) && $stable(z_o))); // R7

  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == OP_RSV) |=> ($stable(res_o) && $stable(x_o) && $stable(z_o) && $stable(n_o))); // R8
endmodule

// File: tb/bcd_arith_unit_tb.sv
module bcd_arith_unit_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       valid_i;
  logic [1:0] op_i;
  logic [7:0] src_i, dst_i;
  logic       x_i, z_i;
  logic [7:0] res_o;
  logic       x_o, c_o, z_o, n_o, v_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bcd_arith_unit u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
    .src_i(src_i), .dst_i(dst_i), .x_i(x_i), .z_i(z_i),
    .res_o(res_o), .x_o(x_o), .c_o(c_o), .z_o(z_o), .n_o(n_o), .v_o(v_o)
  );

  function automatic int to_int(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  // returns {carry, result}
  function automatic logic [8:0] model(input logic [1:0] op, input logic [7:0] s,
                                       input logic [7:0] d, input logic x);
    int t;
    logic cy;
    case (op)
      2'd0: begin t = to_int(d) + to_int(s) + int'(x); cy = (t >= 100); if (cy) t -= 100; end
      2'd1: begin t = to_int(d) - to_int(s) - int'(x); cy = (t < 0); if (cy) t += 100; end
      default: begin t = 0 - to_int(s) - int'(x); cy = (t < 0); if (cy) t += 100; end
    endcase
    return {cy, to_bcd(t)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [7:0] s, input logic [7:0] d,
                        input logic x, input logic z);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; src_i = s; dst_i = d; x_i = x; z_i = z;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic check_op(input string req, input logic [1:0] op, input logic [7:0] s,
                          input logic [7:0] d, input logic x, input logic z);
    logic [8:0] e;
    e = model(op, s, d, x);
    run_op(op, s, d, x, z);
    check(req, {res_o, x_o, c_o}, {e[7:0], e[8], e[8]});
    check({req, " zero"}, z_o, (e[7:0] != 0) ? 1'b0 : z);
    check("R6", {n_o, v_o}, {e[7], 1'b0});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] hold_r;
    logic       hold_x, hold_z, hold_n;
    void'($urandom(32'd20240611));
    rst = 1'b1; valid_i = 0; op_i = 0; src_i = 0; dst_i = 0; x_i = 0; z_i = 0;
    repeat (3) @(negedge clk);
    check("R1", {res_o, x_o, c_o, z_o, n_o, v_o}, '0);
    rst = 1'b0;

    // directed corners
    check_op("R2", 2'd0, 8'h99, 8'h99, 1'b1, 1'b1);   // 99, carry
    check_op("R2", 2'd0, 8'h45, 8'h55, 1'b0, 1'b1);   // 00, carry, zero kept
    check_op("R3", 2'd1, 8'h01, 8'h10, 1'b0, 1'b1);   // 09
    check_op("R3", 2'd1, 8'h01, 8'h00, 1'b0, 1'b1);   // 99 borrow
    check_op("R4", 2'd2, 8'h25, 8'h77, 1'b0, 1'b1);   // ten's complement 75
    check_op("R4", 2'd2, 8'h25, 8'h77, 1'b1, 1'b1);   // nine's complement 74
    check_op("R4", 2'd2, 8'h00, 8'h33, 1'b0, 1'b1);   // 00 no borrow
    check_op("R5", 2'd0, 8'h00, 8'h00, 1'b0, 1'b0);   // zero result, zero in low

    // R9 non-BCD digits
    run_op(2'd0, 8'h00, 8'h0A, 1'b0, 1'b1);
    check("R9 add", {res_o, c_o}, {8'h10, 1'b0});
    run_op(2'd1, 8'h0F, 8'h00, 1'b0, 1'b1);
    check("R9 sub", {res_o, c_o}, {8'h9B, 1'b1});

    // R7 hold while idle
    run_op(2'd0, 8'h12, 8'h34, 1'b0, 1'b1);
    hold_r = res_o; hold_x = x_o; hold_z = z_o; hold_n = n_o;
    @(negedge clk); src_i = 8'h99; dst_i = 8'h99; x_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", {res_o, x_o, z_o, n_o}, {hold_r, hold_x, hold_z, hold_n});

    // R8 reserved code ignored
    run_op(2'd3, 8'h55, 8'h66, 1'b1, 1'b0);
    check("R8", {res_o, x_o, z_o, n_o}, {hold_r, hold_x, hold_z, hold_n});

    // chained 4-byte strings: R2/R3/R5
    for (int k = 0; k < 40; k++) begin
      logic [1:0] op;
      logic [7:0] a [4];
      logic [7:0] b [4];
      logic [7:0] r [4];
      longint av, bv, rv, ev;
      logic xr, zr;
      op = (k % 2 == 0) ? 2'd0 : 2'd1;
      av = 0; bv = 0;
      for (int j = 3; j >= 0; j--) begin
        a[j] = {4'($urandom_range(9)), 4'($urandom_range(9))};
        b[j] = (k % 5 == 4) ? a[j] : {4'($urandom_range(9)), 4'($urandom_range(9))};
        av = av * 100 + longint'(to_int(a[j]));
        bv = av == av ? bv * 100 + longint'(to_int(b[j])) : 0;
      end
      xr = 1'b0; zr = 1'b1;
      for (int j = 0; j < 4; j++) begin
        run_op(op, b[j], a[j], xr, zr);
        r[j] = res_o; xr = x_o; zr = z_o;
      end
      rv = 0;
      for (int j = 3; j >= 0; j--) rv = rv * 100 + longint'(to_int(r[j]));
      if (op == 2'd0) ev = av + bv; else ev = av - bv;
      if (op == 2'd0) begin
        check("R2 chain", {32'(rv), 31'd0, xr}, {32'(ev % 100000000), 31'd0, ev >= 100000000});
      end else begin
        check("R3 chain", {32'(rv), 31'd0, xr},
              {32'((ev < 0) ? ev + 100000000 : ev), 31'd0, ev < 0});
      end
      check("R5 chain", zr, (rv == 0));
    end

    // random single-byte operations
    for (int k = 0; k < 300; k++) begin
      logic [1:0] op;
      op = 2'($urandom_range(2));
      check_op(op == 2'd0 ? "R2" : (op == 2'd1 ? "R3" : "R4"), op,
               {4'($urandom_range(9)), 4'($urandom_range(9))},
               {4'($urandom_range(9)), 4'($urandom_range(9))},
               1'($urandom_range(1)), 1'($urandom_range(1)));
    end

    // reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 again", {res_o, x_o, c_o, z_o, n_o, v_o}, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule